// File: doc/BRIEF.md
# Multi-mode PWM timer channel

This block is one timer channel that produces two PWM waveforms from one shared 32-bit counter. The counter can run as an up sawtooth, a down sawtooth or an up/down triangle. Its count clock is the core clock divided by a power of four. A period register sets where the count turns or wraps. Two compare registers, A and B, each control one output pin. Whenever the count equals a pin's compare value, that pin takes a programmable action. At the end of each count cycle it takes a second programmable action. It starts from a programmable level.

Software drives the block through a write-only register port. Period and compare values can be double-buffered. In that case a write goes to a shadow copy, and the shadow moves into the live register at a defined turning point of the count. In triangle mode, moving compare values at the crest gives waveforms whose two halves differ, which makes asymmetric PWM. The block also emits a one-cycle pulse when the count overflows (saw-up wrap or triangle crest) and another when it underflows (saw-down wrap or triangle trough).

Register map (wr_addr): 0 control, 1 period, 2 compare A, 3 compare B, 4 counter, 5 pin setup.
- Control bits: bit 0 run, bits 2:1 count mode, bits 6:4 prescale select, bit 8 buffering on, bit 9 transfer point.
- Pin setup: bits 4:0 are the action code for pin A and bit 5 enables pin A. Bits 12:8 are the action code for pin B and bit 13 enables pin B.

Top module: `pwm_timer_channel`

## Requirements
- R1: After reset the counter reads 0, the channel is stopped, and both pins and both event pulses are low.
- R2: With mode code 0 (up sawtooth), each count tick moves the counter up by one. On a tick where the count is at or above the period, the counter goes to 0 instead and ovf_o is high for exactly one clock.
- R3: With mode code 1 (down sawtooth), each tick moves the counter down by one. On a tick at count 0, the counter reloads the period and udf_o is high for one clock.
- R4: With mode code 2 (triangle), the count climbs to the period and then descends to 0. A tick at the crest makes ovf_o pulse and the next count is one below. A tick at the trough makes udf_o pulse and the next count is 1. A start always begins upward.
- R5: A count tick occurs once every 4^n clocks, where n is the 3-bit prescale select. Select values above 5 act as 5, which gives a division of 1024. The divider restarts when the channel starts.
- R6: A pin's 5-bit action code is laid out as follows. Bit 4 is the level loaded on start. Bits 3:2 give the action at cycle end. Bits 1:0 give the action on compare match. Each 2-bit action is 00 hold, 01 drive low, 10 drive high, 11 toggle. The cycle end is the overflow in mode 0 and the underflow in modes 1 and 2, and it takes priority over a match on the same tick. Code 0x1B therefore starts high, returns high every cycle and toggles on each match.
- R7: A pin reads low whenever its enable bit is clear or the channel is stopped.
- R8: While running, a control write updates only the run bit; mode, prescale, buffering and transfer point keep their values. Counter writes are also ignored while running.
- R9: A counter write while stopped sets the value counting resumes from.
- R10: With buffering on and the channel running, period and compare writes go to shadow copies. Those copies move to the live registers at a set event: the overflow in mode 0, the underflow in mode 1, and in mode 2 the crest when bit 9 is 1 or the trough when bit 9 is 0. With buffering off, or while stopped, writes take effect at once.
- R11: A compare value greater than the period never matches, so that pin keeps its cycle-end level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| cnt_o | output | 32 | Current counter value |
| pin_a_o | output | 1 | Output pin driven by compare A |
| pin_b_o | output | 1 | Output pin driven by compare B |
| ovf_o | output | 1 | One-cycle overflow / crest pulse |
| udf_o | output | 1 | One-cycle underflow / trough pulse |

## Verification
The hardest state to reach is a buffered compare or period write that lands mid-cycle in triangle mode. The live value must stay unchanged until the chosen crest or trough and then switch on that exact tick. The stimulus starts a triangle count with buffering and crest transfer selected, writes new compare and period values while the count is partway up, and repeats the sequence with trough transfer. A behavioural model predicts every pin edge and pulse clock by clock.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    typedef enum logic [1:0] {
        CM_SAW_UP = 2'd0,
        CM_SAW_DN = 2'd1,
        CM_TRI    = 2'd2,
        CM_RSV    = 2'd3
    } cnt_mode_e;

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_PER  = 3'd1;
    localparam logic [2:0] RA_CMPA = 3'd2;
    localparam logic [2:0] RA_CMPB = 3'd3;
    localparam logic [2:0] RA_CNT  = 3'd4;
    localparam logic [2:0] RA_PIN  = 3'd5;

    typedef struct packed {
        logic      xfer_crest;
        logic      buf_en;
        logic [2:0] ps_sel;
        cnt_mode_e mode;
        logic      run;
    } ctrl_t;

    typedef struct packed {
        logic       en;
        logic       init_hi;
        logic [1:0] end_act;
        logic [1:0] match_act;
    } pin_cfg_t;

    function automatic logic pin_act(input logic [1:0] act, input logic cur);
        case (act)
            2'b00:   pin_act = cur;
            2'b01:   pin_act = 1'b0;
            2'b10:   pin_act = 1'b1;
            default: pin_act = ~cur;
        endcase
    endfunction

endpackage

// File: rtl/pwm_tmr_prescaler.sv
module pwm_tmr_prescaler #(
    parameter int SEL_W   = 3,
    parameter int MAX_SEL = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             start,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = 2 * MAX_SEL;

    logic [PRE_W-1:0] pre_d, pre_q, lim;
    logic [SEL_W-1:0] eff;

    always_comb begin
        eff   = (sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel;
        lim   = (PRE_W'(1) << (2 * eff)) - PRE_W'(1);
        tick  = run && (pre_q == lim);
        pre_d = pre_q;
        if (start)
            pre_d = '0;
        else if (run)
            pre_d = tick ? '0 : pre_q + PRE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/pwm_tmr_counter.sv
module pwm_tmr_counter
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  cnt_mode_e        mode,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             ev_ovf,
    output logic             ev_udf,
    output logic             ovf_pulse,
    output logic             udf_pulse
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir_up;
        logic             ovf;
        logic             udf;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        ev_ovf = 1'b0;
        ev_udf = 1'b0;
        if (tick) begin
            case (mode)
                CM_SAW_DN: begin
                    if (s_q.cnt == '0) begin
                        s_d.cnt = period;
                        ev_udf  = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt - CNT_W'(1);
                    end
                end
                CM_TRI: begin
                    if (s_q.dir_up) begin
                        if (s_q.cnt >= period) begin
                            ev_ovf     = 1'b1;
                            s_d.dir_up = 1'b0;
                            s_d.cnt    = (s_q.cnt == '0) ? '0 : s_q.cnt - CNT_W'(1);
                        end else begin
                            s_d.cnt = s_q.cnt + CNT_W'(1);
                        end
                    end else begin
                        if (s_q.cnt == '0) begin
                            ev_udf     = 1'b1;
                            s_d.dir_up = 1'b1;
                            s_d.cnt    = (period == '0) ? '0 : CNT_W'(1);
                        end else begin
                            s_d.cnt = s_q.cnt - CNT_W'(1);
                        end
                    end
                end
                default: begin
                    if (s_q.cnt >= period) begin
                        s_d.cnt = '0;
                        ev_ovf  = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + CNT_W'(1);
                    end
                end
            endcase
        end
        if (load)  s_d.cnt    = load_val;
        if (start) s_d.dir_up = 1'b1;
        s_d.ovf = ev_ovf;
        s_d.udf = ev_udf;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{cnt: '0, dir_up: 1'b1, ovf: 1'b0, udf: 1'b0};
        else        s_q <= s_d;
    end

    assign cnt       = s_q.cnt;
    assign ovf_pulse = s_q.ovf;
    assign udf_pulse = s_q.udf;
endmodule

// File: rtl/pwm_tmr_pin.sv
module pwm_tmr_pin
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             run,
    input  logic             cyc_end,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  pin_cfg_t         cfg,
    output logic             pin
);
    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_q;
        if (start)
            lvl_d = cfg.init_hi;
        else if (tick) begin
            if (cyc_end)
                lvl_d = pin_act(cfg.end_act, lvl_q);
            else if (cnt == cmp)
                lvl_d = pin_act(cfg.match_act, lvl_q);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

    assign pin = lvl_q && cfg.en && run;
endmodule

// File: rtl/pwm_timer_channel.sv
module pwm_timer_channel
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int SEL_W   = 3,
    parameter int MAX_SEL = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pin_a_o,
    output logic             pin_b_o,
    output logic             ovf_o,
    output logic             udf_o
);
    localparam int NUM_PINS = 2;

    typedef struct packed {
        ctrl_t                             ctrl;
        logic [CNT_W-1:0]                  per;
        logic [CNT_W-1:0]                  per_buf;
        logic [NUM_PINS-1:0][CNT_W-1:0]    cmp;
        logic [NUM_PINS-1:0][CNT_W-1:0]    cmp_buf;
        pin_cfg_t [NUM_PINS-1:0]           pcfg;
    } regs_t;

    regs_t r_d, r_q;

    logic                tick, start, load, ev_ovf, ev_udf, cyc_end, xfer;
    logic [NUM_PINS-1:0] pin_w;

    assign start = wr_en && (wr_addr == RA_CTRL) && wr_data[0] && !r_q.ctrl.run;
    assign load  = wr_en && (wr_addr == RA_CNT) && !r_q.ctrl.run;

    always_comb begin
        cyc_end = (r_q.ctrl.mode == CM_SAW_DN || r_q.ctrl.mode == CM_TRI) ? ev_udf : ev_ovf;
        if (r_q.ctrl.mode == CM_TRI)
            xfer = r_q.ctrl.buf_en && (r_q.ctrl.xfer_crest ? ev_ovf : ev_udf);
        else
            xfer = r_q.ctrl.buf_en && cyc_end;
    end

    always_comb begin
        r_d = r_q;
        if (xfer) begin
            r_d.per = r_q.per_buf;
            r_d.cmp = r_q.cmp_buf;
        end
        if (wr_en) begin
            case (wr_addr)
                RA_CTRL: begin
                    if (r_q.ctrl.run) begin
                        r_d.ctrl.run = wr_data[0];
                    end else begin
                        r_d.ctrl.run        = wr_data[0];
                        r_d.ctrl.mode       = cnt_mode_e'(wr_data[2:1]);
                        r_d.ctrl.ps_sel     = wr_data[6:4];
                        r_d.ctrl.buf_en     = wr_data[8];
                        r_d.ctrl.xfer_crest = wr_data[9];
                    end
                end
                RA_PER: begin
                    r_d.per_buf = wr_data;
                    if (!r_q.ctrl.buf_en || !r_q.ctrl.run) r_d.per = wr_data;
                end
                RA_CMPA, RA_CMPB: begin
                    r_d.cmp_buf[wr_addr[0]] = wr_data;
                    if (!r_q.ctrl.buf_en || !r_q.ctrl.run) r_d.cmp[wr_addr[0]] = wr_data;
                end
                RA_PIN: begin
                    r_d.pcfg[0] = pin_cfg_t'({wr_data[5], wr_data[4:0]});
                    r_d.pcfg[1] = pin_cfg_t'({wr_data[13], wr_data[12:8]});
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    pwm_tmr_prescaler #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.ctrl.run),
        .start (start),
        .sel   (r_q.ctrl.ps_sel),
        .tick  (tick)
    );

    pwm_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .start     (start),
        .load      (load),
        .load_val  (wr_data),
        .mode      (r_q.ctrl.mode),
        .period    (r_q.per),
        .cnt       (cnt_o),
        .ev_ovf    (ev_ovf),
        .ev_udf    (ev_udf),
        .ovf_pulse (ovf_o),
        .udf_pulse (udf_o)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pwm_tmr_pin #(.CNT_W(CNT_W)) u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .start   (start),
            .run     (r_q.ctrl.run),
            .cyc_end (cyc_end),
            .cnt     (cnt_o),
            .cmp     (r_q.cmp[p]),
            .cfg     (r_q.pcfg[p]),
            .pin     (pin_w[p])
        );
    end

    assign pin_a_o = pin_w[0];
    assign pin_b_o = pin_w[1];
endmodule

// File: rtl/pwm_timer_channel_sva.sv
module pwm_timer_channel_sva #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [1:0]       mode,
    input logic             wr_en,
    input logic [CNT_W-1:0] cnt,
    input logic             pin_a,
    input logic             pin_b,
    input logic             ovf,
    input logic             udf
);
    // R2 R3 R4: the two event pulses never coincide
    a_r4_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && udf));

    // R2: an up-sawtooth overflow leaves the counter at zero
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && mode == 2'd0) |-> (cnt == '0));

    // R7: stopped channel keeps both pins low
    a_r7_pins_low_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!pin_a && !pin_b));

    // R8: count mode is frozen while running
    a_r8_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(mode));

    // R9: a stopped counter without a write keeps its value
    a_r9_count_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run && !wr_en) |-> $stable(cnt));
endmodule

bind pwm_timer_channel pwm_timer_channel_sva #(.CNT_W(CNT_W)) u_sva (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (r_q.ctrl.run),
    .mode  (r_q.ctrl.mode),
    .wr_en (wr_en),
    .cnt   (cnt_o),
    .pin_a (pin_a_o),
    .pin_b (pin_b_o),
    .ovf   (ovf_o),
    .udf   (udf_o)
);

// File: tb/pwm_timer_channel_tb.sv
module pwm_timer_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] cnt_o;
    logic        pin_a_o, pin_b_o, ovf_o, udf_o;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    pwm_timer_channel u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_o(cnt_o), .pin_a_o(pin_a_o), .pin_b_o(pin_b_o), .ovf_o(ovf_o), .udf_o(udf_o)
    );

    // behavioural reference model
    longint m_cnt, m_per, m_per_b, m_pre;
    longint m_cmp[2], m_cmpb[2];
    int     m_mode, m_ps;
    bit     m_run, m_buf, m_crest, m_dir, m_ovf, m_udf;
    bit     m_lvl[2], m_en[2];
    int     m_code[2];

    function automatic bit act_of(int a, bit cur);
        if (a == 0) return cur;
        if (a == 1) return 0;
        if (a == 2) return 1;
        return !cur;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_per = 0; m_per_b = 0; m_pre = 0; m_mode = 0; m_ps = 0;
            m_run = 0; m_buf = 0; m_crest = 0; m_dir = 1; m_ovf = 0; m_udf = 0;
            foreach (m_lvl[i]) begin
                m_lvl[i] = 0; m_en[i] = 0; m_code[i] = 0; m_cmp[i] = 0; m_cmpb[i] = 0;
            end
        end else begin
            longint lim, ncnt, npre;
            bit tk, eo, eu, ndir, cend, xf;
            bit nl[2];
            int eff;
            eff  = (m_ps > 5) ? 5 : m_ps;
            lim  = (longint'(1) << (2 * eff)) - 1;
            tk   = m_run && (m_pre == lim);
            eo = 0; eu = 0; ncnt = m_cnt; ndir = m_dir;
            if (tk) begin
                if (m_mode == 1) begin
                    if (m_cnt == 0) begin ncnt = m_per; eu = 1; end
                    else ncnt = m_cnt - 1;
                end else if (m_mode == 2) begin
                    if (m_dir) begin
                        if (m_cnt >= m_per) begin eo = 1; ndir = 0; ncnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
                        else ncnt = m_cnt + 1;
                    end else begin
                        if (m_cnt == 0) begin eu = 1; ndir = 1; ncnt = (m_per == 0) ? 0 : 1; end
                        else ncnt = m_cnt - 1;
                    end
                end else begin
                    if (m_cnt >= m_per) begin eo = 1; ncnt = 0; end
                    else ncnt = m_cnt + 1;
                end
            end
            ncnt = ncnt & 64'hFFFF_FFFF;
            cend = (m_mode == 1 || m_mode == 2) ? eu : eo;
            for (int p = 0; p < 2; p++) begin
                nl[p] = m_lvl[p];
                if (tk) begin
                    if (cend) nl[p] = act_of((m_code[p] >> 2) & 3, m_lvl[p]);
                    else if (m_cnt == m_cmp[p]) nl[p] = act_of(m_code[p] & 3, m_lvl[p]);
                end
            end
            npre = m_run ? (tk ? 0 : m_pre + 1) : m_pre;
            xf = m_buf && ((m_mode == 2) ? (m_crest ? eo : eu) : cend);
            if (xf) begin
                m_per = m_per_b; m_cmp[0] = m_cmpb[0]; m_cmp[1] = m_cmpb[1];
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin
                        if (!m_run) begin
                            m_mode = int'(wr_data[2:1]); m_ps = int'(wr_data[6:4]);
                            m_buf = wr_data[8]; m_crest = wr_data[9];
                            if (wr_data[0]) begin
                                npre = 0; ndir = 1;
                                nl[0] = m_code[0][4]; nl[1] = m_code[1][4];
                            end
                        end
                        m_run = wr_data[0];
                    end
                    3'd1: begin
                        m_per_b = wr_data;
                        if (!m_buf || !m_run) m_per = wr_data;
                    end
                    3'd2, 3'd3: begin
                        m_cmpb[wr_addr - 2] = wr_data;
                        if (!m_buf || !m_run) m_cmp[wr_addr - 2] = wr_data;
                    end
                    3'd4: if (!m_run) ncnt = wr_data;
                    3'd5: begin
                        m_code[0] = int'(wr_data[4:0]);  m_en[0] = wr_data[5];
                        m_code[1] = int'(wr_data[12:8]); m_en[1] = wr_data[13];
                    end
                    default: ;
                endcase
            end
            m_cnt = ncnt; m_pre = npre; m_dir = ndir;
            m_lvl[0] = nl[0]; m_lvl[1] = nl[1];
            m_ovf = eo; m_udf = eu;
        end
    end

    task automatic chk(string what, longint got, longint exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s got %0h expected %0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("cnt", cnt_o, m_cnt);
            chk("pin_a", pin_a_o, m_run && m_en[0] && m_lvl[0]);
            chk("pin_b", pin_b_o, m_run && m_en[1] && m_lvl[1]);
            chk("ovf", ovf_o, m_ovf);
            chk("udf", udf_o, m_udf);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog %s got timeout expected completion", tag);
        finish_run();
    end

    initial begin
        tag = "R1"; idle(5);
        rst_n = 1'b1; idle(5);
        // R6: both pins 0x1B and enabled
        tag = "R6"; wr(3'd5, 32'h3B3B); wr(3'd1, 9); wr(3'd2, 3); wr(3'd3, 7);
        wr(3'd0, 32'h1);
        tag = "R2"; idle(25);
        tag = "R6"; idle(25);
        tag = "R7"; wr(3'd5, 32'h3B1B); idle(15); wr(3'd5, 32'h3B3B); idle(4);
        wr(3'd0, 32'h0); idle(10);
        tag = "R9"; wr(3'd4, 5); idle(3); wr(3'd0, 32'h3);
        tag = "R3"; idle(40);
        tag = "R8"; wr(3'd0, 32'h125); wr(3'd4, 0); idle(30); wr(3'd0, 32'h0);
        tag = "R5"; wr(3'd4, 0); wr(3'd0, 32'h11); idle(60); wr(3'd0, 0);
        wr(3'd1, 2); wr(3'd0, 32'h71); idle(4200); wr(3'd0, 0);
        tag = "R4"; wr(3'd4, 0); wr(3'd1, 6); wr(3'd2, 2); wr(3'd3, 5);
        wr(3'd0, 32'h5); idle(60); wr(3'd0, 0);
        tag = "R11"; wr(3'd3, 20); wr(3'd4, 0); wr(3'd0, 32'h1); idle(40); wr(3'd0, 0);
        tag = "R10"; wr(3'd1, 8); wr(3'd2, 2); wr(3'd3, 6); wr(3'd4, 0);
        wr(3'd0, 32'h305); idle(10); wr(3'd2, 5); wr(3'd1, 10); idle(60); wr(3'd0, 0);
        wr(3'd4, 0); wr(3'd0, 32'h105); idle(7); wr(3'd3, 3); idle(60); wr(3'd0, 0);
        wr(3'd4, 0); wr(3'd0, 32'h101); idle(3); wr(3'd1, 4); idle(40); wr(3'd0, 0);
        wr(3'd0, 32'h1); idle(3); wr(3'd2, 1); idle(20); wr(3'd0, 0); idle(5);
        finish_run();
    end
endmodule